// File: doc/BRIEF.md
# USB Endpoint Handshake Control

This block keeps the control state of a single bulk or interrupt endpoint in a USB device controller. When the packet engine reports a token, the block picks the handshake answer: send data or accept data, NAK, or STALL. For IN tokens it also gives the number of bytes to send. It keeps the endpoint's data toggle, and it changes some of its own control bits when a transaction ends.

Software reaches the block through one 6-bit control register and a 10-bit max packet size. The max packet size is split into a high part and a low part. The packet engine marks each transaction with two pulses: a token pulse (`tok_valid`) at the start and a completion pulse (`xact_done`) at the end. Between these two pulses the endpoint is busy. Any STALL or NAK setting written while the endpoint is busy is held back. It takes effect when the transaction ends. The FIFO reports its byte count and its free space. The block only compares these counts and never touches the FIFO storage.

Top module: `usb_ep_handshake`

## Requirements
- R1: Response codes on `resp` are 0 = NAK, 1 = data (send on IN, ACK on OUT) and 2 = STALL. While control bit 0 (stall) reads 1, every accepted token is answered with 2, whatever control bit 1 (nak) holds.
- R2: While nak (control bit 1) reads 1 and stall reads 0, every accepted token is answered with 0, whatever the FIFO count or free space.
- R3: A control write while `busy` is 1 leaves read-back bits 1:0 unchanged until the completion pulse. At the completion pulse the written stall and nak values take effect, and the following token obeys them. A token that arrives while `busy` is 1 is ignored.
- R4: With no forcing, an IN token gets the following answers, each with `resp_vld` pulsed one cycle after the token:
  - If the FIFO count is at least the max packet size, the answer is data with `tx_len` equal to the max packet size.
  - If the count is smaller and short enable (control bit 5) is 1, the answer is data with `tx_len` equal to the count. A count of 0 gives a zero-length packet.
  - Otherwise the answer is NAK.
  - Every non-data answer has `tx_len` equal to 0.
- R5: A successful IN completion after a data answer shorter than the max packet size clears short enable. A full-size answer leaves it set.
- R6: With no forcing, an OUT token is answered with data (ACK) when FIFO free space is at least the max packet size. Otherwise it is answered with NAK.
- R7: An OUT transaction may complete successfully after an ACK with a received length below the max packet size. If auto-NAK disable (control bit 4) is 0, this sets nak. If that bit is 1, nak is left unchanged.
- R8: The toggle inverts after each successful completion of a data answer. It does not change after NAK, STALL, or a completion with the success flag low.
- R9: A control write with bit 3 = 1 sets the toggle, and one with bit 2 = 1 clears it. When both bits are 1, clear wins. The current toggle reads back on control bit 2 and on `toggle`.
- R10: The max packet size is `{high[1:0], low[7:0]}`. High bits 7:2 always read 0.
- R11: After reset, all control read-back bits are 0, both size registers read 0, and `toggle`, `busy` and `resp_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | 0 stall, 1 nak, 2 toggle clear, 3 toggle set, 4 auto-NAK disable, 5 short enable |
| mps_hi_wr | input | 1 | Write strobe for the high part of the max packet size |
| mps_lo_wr | input | 1 | Write strobe for the low part of the max packet size |
| mps_wdata | input | 8 | Write data for either part of the size |
| tok_valid | input | 1 | Token pulse that starts a transaction |
| tok_in | input | 1 | 1 = IN token, 0 = OUT token |
| xact_done | input | 1 | Completion pulse that ends a transaction |
| xact_ok | input | 1 | Completion was successful (host ACK on IN, good packet on OUT) |
| rx_len | input | 11 | Received OUT packet length, valid with `xact_done` |
| fifo_count | input | 11 | Bytes held in the FIFO |
| fifo_free | input | 11 | Free bytes in the FIFO |
| resp_vld | output | 1 | One-cycle pulse: a new response is available |
| resp | output | 2 | Response code, held until the next token |
| tx_len | output | 11 | Bytes to send, held with `resp` |
| toggle | output | 1 | Current data toggle |
| busy | output | 1 | A transaction is in progress |
| ctl_rdata | output | 6 | 0 stall, 1 nak, 2 toggle, 3 zero, 4 auto-NAK disable, 5 short enable |
| mps_hi_rdata | output | 8 | High part of the size, upper bits 0 |
| mps_lo_rdata | output | 8 | Low part of the size |

## Verification
Some behaviour is checked by the assertions on every cycle:
- the STALL-over-NAK priority and forced NAK at each accepted token;
- that a write during a transaction does not move the effective force bits;
- the zero length on non-data answers;
- that the toggle holds or inverts exactly as completions dictate.

Other behaviour depends on FIFO levels and on history across several transactions, so only the bench scenarios can show it:
- the choice between full, short and zero-length IN packets;
- short enable clearing itself only after a short packet;
- auto-NAK on a short OUT and its disable bit;
- the clear-over-set toggle write.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
   typedef enum logic [1:0] {
      RSP_NAK   = 2'd0,
      RSP_DATA  = 2'd1,
      RSP_STALL = 2'd2
   } rsp_e;

   localparam int CTL_W    = 6;
   localparam int CB_STALL = 0;
   localparam int CB_NAK   = 1;
   localparam int CB_TCLR  = 2;   // write: clear toggle, read: toggle state
   localparam int CB_TSET  = 3;
   localparam int CB_ADIS  = 4;
   localparam int CB_SHORT = 5;
endpackage

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
   import ep_hs_pkg::*;
#(
   parameter int MPS_W = 10,
   parameter int CNT_W = 11
) (
   input  logic             stall,
   input  logic             nak,
   input  logic             short_en,
   input  logic             tok_in,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic [CNT_W-1:0] fifo_free,
   input  logic [MPS_W-1:0] mps,
   output rsp_e             rsp,
   output logic [CNT_W-1:0] len
);
   logic [CNT_W-1:0] mps_x;
   assign mps_x = CNT_W'(mps);

   always_comb begin
      rsp = RSP_NAK;
      len = '0;
      if (stall) begin
         rsp = RSP_STALL;
      end else if (nak) begin
         rsp = RSP_NAK;
      end else if (tok_in) begin
         if (fifo_count >= mps_x) begin
            rsp = RSP_DATA;
            len = mps_x;
         end else if (short_en) begin
            rsp = RSP_DATA;
            len = fifo_count;
         end
      end else if (fifo_free >= mps_x) begin
         rsp = RSP_DATA;
      end
   end
endmodule

// File: rtl/ep_hs_flags.sv
module ep_hs_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic w_stall,
   input  logic w_nak,
   input  logic w_adis,
   input  logic w_short,
   input  logic busy,
   input  logic done,
   input  logic clr_short,
   input  logic set_nak,
   output logic stall,
   output logic nak,
   output logic adis,
   output logic short_en
);
   logic st_q, nk_q, ad_q, sh_q, pv_q, ps_q, pn_q;
   logic st_d, nk_d, ad_d, sh_d, pv_d, ps_d, pn_d;

   always_comb begin
      st_d = st_q; nk_d = nk_q; ad_d = ad_q; sh_d = sh_q;
      pv_d = pv_q; ps_d = ps_q; pn_d = pn_q;
      if (done) begin
         if (pv_q) begin
            st_d = ps_q;
            nk_d = pn_q;
         end
         pv_d = 1'b0;
         if (set_nak)   nk_d = 1'b1;
         if (clr_short) sh_d = 1'b0;
      end
      if (wr) begin
         ad_d = w_adis;
         sh_d = w_short;
         if (busy && !done) begin
            pv_d = 1'b1;
            ps_d = w_stall;
            pn_d = w_nak;
         end else begin
            st_d = w_stall;
            nk_d = w_nak;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= 1'b0; nk_q <= 1'b0; ad_q <= 1'b0; sh_q <= 1'b0;
         pv_q <= 1'b0; ps_q <= 1'b0; pn_q <= 1'b0;
      end else begin
         st_q <= st_d; nk_q <= nk_d; ad_q <= ad_d; sh_q <= sh_d;
         pv_q <= pv_d; ps_q <= ps_d; pn_q <= pn_d;
      end
   end

   assign stall    = st_q;
   assign nak      = nk_q;
   assign adis     = ad_q;
   assign short_en = sh_q;
endmodule

// File: rtl/ep_hs_toggle.sv
module ep_hs_toggle #(
   parameter bit CLR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flip,
   input  logic set,
   input  logic clr,
   output logic tog
);
   logic tog_q, tog_d;

   generate
      if (CLR_WINS) begin : g_clr_first
         always_comb begin
            if (clr)       tog_d = 1'b0;
            else if (set)  tog_d = 1'b1;
            else if (flip) tog_d = ~tog_q;
            else           tog_d = tog_q;
         end
      end else begin : g_set_first
         always_comb begin
            if (set)       tog_d = 1'b1;
            else if (clr)  tog_d = 1'b0;
            else if (flip) tog_d = ~tog_q;
            else           tog_d = tog_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= tog_d;
   end

   assign tog = tog_q;
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
   import ep_hs_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int MPS_W    = 10,
   parameter int CNT_W    = 11,
   parameter bit CLR_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             mps_hi_wr,
   input  logic             mps_lo_wr,
   input  logic [REG_W-1:0] mps_wdata,
   input  logic             tok_valid,
   input  logic             tok_in,
   input  logic             xact_done,
   input  logic             xact_ok,
   input  logic [CNT_W-1:0] rx_len,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic [CNT_W-1:0] fifo_free,
   output logic             resp_vld,
   output logic [1:0]       resp,
   output logic [CNT_W-1:0] tx_len,
   output logic             toggle,
   output logic             busy,
   output logic [CTL_W-1:0] ctl_rdata,
   output logic [REG_W-1:0] mps_hi_rdata,
   output logic [REG_W-1:0] mps_lo_rdata
);
   localparam int HI_W = MPS_W - REG_W;

   generate
      if (HI_W < 1 || HI_W >= REG_W) begin : g_bad_mps_w
         $error("MPS_W must exceed REG_W and fit in two registers");
      end
      if (CNT_W <= MPS_W) begin : g_bad_cnt_w
         $error("CNT_W must be wider than MPS_W");
      end
   endgenerate

   // max packet size registers
   logic [HI_W-1:0]  mps_hi_q;
   logic [REG_W-1:0] mps_lo_q;
   logic [MPS_W-1:0] mps;
   logic [CNT_W-1:0] mps_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mps_hi_q <= '0;
         mps_lo_q <= '0;
      end else begin
         if (mps_hi_wr) mps_hi_q <= mps_wdata[HI_W-1:0];
         if (mps_lo_wr) mps_lo_q <= mps_wdata;
      end
   end

   assign mps          = {mps_hi_q, mps_lo_q};
   assign mps_x        = CNT_W'(mps);
   assign mps_hi_rdata = REG_W'(mps_hi_q);
   assign mps_lo_rdata = mps_lo_q;

   // transaction tracking
   logic             busy_q, vld_q, in_q;
   rsp_e             rsp_q, rsp_d;
   logic [CNT_W-1:0] len_q, len_d;
   logic             tok_acc, done_acc, data_done, clr_short, set_nak;
   logic             f_stall, f_nak, f_adis, f_short, tog;

   assign tok_acc   = tok_valid & ~busy_q;
   assign done_acc  = xact_done & busy_q;
   assign data_done = done_acc & xact_ok & (rsp_q == RSP_DATA);
   assign clr_short = data_done & in_q & (len_q < mps_x);
   assign set_nak   = data_done & ~in_q & (rx_len < mps_x) & ~f_adis;

   ep_hs_decide #(.MPS_W(MPS_W), .CNT_W(CNT_W)) u_decide (
      .stall      (f_stall),
      .nak        (f_nak),
      .short_en   (f_short),
      .tok_in     (tok_in),
      .fifo_count (fifo_count),
      .fifo_free  (fifo_free),
      .mps        (mps),
      .rsp        (rsp_d),
      .len        (len_d)
   );

   ep_hs_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctl_wr),
      .w_stall   (ctl_wdata[CB_STALL]),
      .w_nak     (ctl_wdata[CB_NAK]),
      .w_adis    (ctl_wdata[CB_ADIS]),
      .w_short   (ctl_wdata[CB_SHORT]),
      .busy      (busy_q),
      .done      (done_acc),
      .clr_short (clr_short),
      .set_nak   (set_nak),
      .stall     (f_stall),
      .nak       (f_nak),
      .adis      (f_adis),
      .short_en  (f_short)
   );

   ep_hs_toggle #(.CLR_WINS(CLR_WINS)) u_toggle (
      .clk   (clk),
      .rst_n (rst_n),
      .flip  (data_done),
      .set   (ctl_wr & ctl_wdata[CB_TSET]),
      .clr   (ctl_wr & ctl_wdata[CB_TCLR]),
      .tog   (tog)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         vld_q  <= 1'b0;
         in_q   <= 1'b0;
         rsp_q  <= RSP_NAK;
         len_q  <= '0;
      end else begin
         vld_q <= tok_acc;
         if (tok_acc) begin
            busy_q <= 1'b1;
            in_q   <= tok_in;
            rsp_q  <= rsp_d;
            len_q  <= len_d;
         end else if (done_acc) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_comb begin
      ctl_rdata           = '0;
      ctl_rdata[CB_STALL] = f_stall;
      ctl_rdata[CB_NAK]   = f_nak;
      ctl_rdata[CB_TCLR]  = tog;
      ctl_rdata[CB_ADIS]  = f_adis;
      ctl_rdata[CB_SHORT] = f_short;
   end

   assign resp_vld = vld_q;
   assign resp     = rsp_q;
   assign tx_len   = len_q;
   assign toggle   = tog;
   assign busy     = busy_q;
endmodule

// File: rtl/ep_hs_chk.sv
module ep_hs_chk
   import ep_hs_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic             tok_valid,
   input logic             xact_done,
   input logic             xact_ok,
   input logic             busy,
   input logic             resp_vld,
   input logic [1:0]       resp,
   input logic [CNT_W-1:0] tx_len,
   input logic             toggle,
   input logic [1:0]       force_bits
);
   // R1: stall read-back at an accepted token gives STALL next cycle
   a_r1_stall_wins: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !busy && force_bits[0] |=> resp_vld && resp == RSP_STALL);

   // R2: forced NAK regardless of FIFO levels
   a_r2_nak_forced: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !busy && !force_bits[0] && force_bits[1]
      |=> resp_vld && resp == RSP_NAK);

   // R3: a write inside a transaction does not move the effective force bits
   a_r3_deferred: assert property (@(posedge clk) disable iff (!rst_n)
      busy && ctl_wr && !xact_done |=> $stable(force_bits));

   // R4: non-data responses carry no length
   a_r4_no_len: assert property (@(posedge clk) disable iff (!rst_n)
      resp_vld && resp != RSP_DATA |-> tx_len == '0);

   // R8: toggle holds unless a data transaction completes successfully
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr && !(xact_done && busy && xact_ok && resp == RSP_DATA)
      |=> $stable(toggle));

   // R8: toggle inverts on a successful data completion
   a_r8_flip: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr && xact_done && busy && xact_ok && resp == RSP_DATA
      |=> toggle != $past(toggle));
endmodule

bind usb_ep_handshake ep_hs_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_wr     (ctl_wr),
   .tok_valid  (tok_valid),
   .xact_done  (xact_done),
   .xact_ok    (xact_ok),
   .busy       (busy),
   .resp_vld   (resp_vld),
   .resp       (resp),
   .tx_len     (tx_len),
   .toggle     (toggle),
   .force_bits (ctl_rdata[1:0])
);

// File: tb/sim_usb_ep_handshake.sv
module sim_usb_ep_handshake;
   import ep_hs_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [5:0]  ctl_wdata = '0;
   logic        mps_hi_wr = 1'b0, mps_lo_wr = 1'b0;
   logic [7:0]  mps_wdata = '0;
   logic        tok_valid = 1'b0, tok_in = 1'b0;
   logic        xact_done = 1'b0, xact_ok = 1'b0;
   logic [10:0] rx_len = '0, fifo_count = '0, fifo_free = '0;
   logic        resp_vld, toggle, busy;
   logic [1:0]  resp;
   logic [10:0] tx_len;
   logic [5:0]  ctl_rdata;
   logic [7:0]  mps_hi_rdata, mps_lo_rdata;

   always #5 clk = ~clk;

   usb_ep_handshake u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .mps_hi_wr(mps_hi_wr), .mps_lo_wr(mps_lo_wr), .mps_wdata(mps_wdata),
      .tok_valid(tok_valid), .tok_in(tok_in), .xact_done(xact_done),
      .xact_ok(xact_ok), .rx_len(rx_len), .fifo_count(fifo_count),
      .fifo_free(fifo_free), .resp_vld(resp_vld), .resp(resp),
      .tx_len(tx_len), .toggle(toggle), .busy(busy), .ctl_rdata(ctl_rdata),
      .mps_hi_rdata(mps_hi_rdata), .mps_lo_rdata(mps_lo_rdata)
   );

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;
   bit exp_tog = 1'b0;

   typedef struct {
      int    r;
      int    l;
      string tag;
   } exp_t;
   exp_t sb[$];

   task automatic check(bit ok, string tag, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pop expected responses as the design produces them
   always @(negedge clk) begin
      if (rst_n && resp_vld) begin
         if (sb.size() == 0) begin
            check(1'b0, "R4 unexpected response", int'(resp), -1);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(int'(resp) == e.r, {e.tag, " resp"}, int'(resp), e.r);
            check(int'(tx_len) == e.l, {e.tag, " len"}, int'(tx_len), e.l);
         end
      end
   end

   task automatic ctl(bit st, bit nk, bit tclr, bit tset, bit adis, bit sh);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = {sh, adis, tset, tclr, nk, st};
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic token(bit in, int cnt, int fre, int er, int el, string tag);
      exp_t e;
      e.r = er; e.l = el; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      tok_valid = 1'b1; tok_in = in;
      fifo_count = 11'(cnt); fifo_free = 11'(fre);
      @(negedge clk);
      tok_valid = 1'b0;
   endtask

   task automatic finish_x(bit ok, int rx);
      @(negedge clk);
      xact_done = 1'b1; xact_ok = ok; rx_len = 11'(rx);
      @(negedge clk);
      xact_done = 1'b0;
   endtask

   task automatic chk_tog(string tag);
      check(toggle == exp_tog, tag, int'(toggle), int'(exp_tog));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(ctl_rdata == 6'd0, "R11 control readback", int'(ctl_rdata), 0);
      check(mps_hi_rdata == 8'd0 && mps_lo_rdata == 8'd0, "R11 size readback",
            int'({mps_hi_rdata, mps_lo_rdata}), 0);
      check(!toggle && !busy && !resp_vld, "R11 outputs idle",
            int'({toggle, busy, resp_vld}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 size registers
      @(negedge clk); mps_hi_wr = 1'b1; mps_wdata = 8'hFF;
      @(negedge clk); mps_hi_wr = 1'b0;
      check(mps_hi_rdata == 8'h03, "R10 high upper bits zero", int'(mps_hi_rdata), 3);
      @(negedge clk); mps_hi_wr = 1'b1; mps_wdata = 8'h00;
      @(negedge clk); mps_hi_wr = 1'b0; mps_lo_wr = 1'b1; mps_wdata = 8'd64;
      @(negedge clk); mps_lo_wr = 1'b0;
      check(mps_lo_rdata == 8'd64 && mps_hi_rdata == 8'd0, "R10 size 64",
            int'({mps_hi_rdata, mps_lo_rdata}), 64);

      // R4 full packet, R8 flip
      token(1, 100, 0, RSP_DATA, 64, "R4 full IN");
      finish_x(1, 0); exp_tog = 1; chk_tog("R8 flip after IN");
      // R8 failed completion leaves toggle
      token(1, 100, 0, RSP_DATA, 64, "R4 full IN again");
      finish_x(0, 0); chk_tog("R8 no flip on failed completion");
      // R4 too little data, no short enable
      token(1, 10, 0, RSP_NAK, 0, "R4 NAK on low FIFO");
      finish_x(1, 0); chk_tog("R8 no flip after NAK");

      // R4/R5 short packet
      ctl(0, 0, 0, 0, 0, 1);
      token(1, 10, 0, RSP_DATA, 10, "R4 short IN");
      finish_x(1, 0); exp_tog = ~exp_tog; chk_tog("R8 flip after short IN");
      check(ctl_rdata[5] == 1'b0, "R5 short enable cleared", int'(ctl_rdata[5]), 0);
      ctl(0, 0, 0, 0, 0, 1);
      token(1, 64, 0, RSP_DATA, 64, "R4 full IN with short enable");
      finish_x(1, 0); exp_tog = ~exp_tog;
      check(ctl_rdata[5] == 1'b1, "R5 short enable kept", int'(ctl_rdata[5]), 1);
      token(1, 0, 0, RSP_DATA, 0, "R4 zero-length IN");
      finish_x(1, 0); exp_tog = ~exp_tog;
      check(ctl_rdata[5] == 1'b0, "R5 cleared after zero-length", int'(ctl_rdata[5]), 0);

      // R6 / R7 OUT
      token(0, 0, 100, RSP_DATA, 0, "R6 OUT ACK");
      finish_x(1, 64); exp_tog = ~exp_tog; chk_tog("R8 flip after OUT");
      check(ctl_rdata[1] == 1'b0, "R7 full OUT no auto NAK", int'(ctl_rdata[1]), 0);
      token(0, 0, 30, RSP_NAK, 0, "R6 OUT NAK on low space");
      finish_x(1, 0); chk_tog("R8 no flip after OUT NAK");
      token(0, 0, 100, RSP_DATA, 0, "R6 OUT ACK short");
      finish_x(1, 5); exp_tog = ~exp_tog;
      check(ctl_rdata[1] == 1'b1, "R7 short OUT sets nak", int'(ctl_rdata[1]), 1);

      // R2 forced NAK ignores FIFO
      token(1, 100, 0, RSP_NAK, 0, "R2 forced NAK IN");
      finish_x(1, 0);
      token(0, 0, 100, RSP_NAK, 0, "R2 forced NAK OUT");
      finish_x(1, 0); chk_tog("R8 no flip on forced NAK");

      // R7 auto-NAK disabled
      ctl(0, 0, 0, 0, 1, 0);
      token(0, 0, 100, RSP_DATA, 0, "R7 OUT ACK with disable");
      finish_x(1, 5); exp_tog = ~exp_tog;
      check(ctl_rdata[1] == 1'b0, "R7 disable keeps nak clear", int'(ctl_rdata[1]), 0);

      // R1 stall over nak
      ctl(1, 1, 0, 0, 1, 0);
      token(1, 100, 0, RSP_STALL, 0, "R1 stall IN");
      finish_x(1, 0); chk_tog("R8 no flip after STALL");
      token(0, 0, 100, RSP_STALL, 0, "R1 stall OUT");
      finish_x(1, 0);

      // R3 deferred write
      ctl(0, 0, 0, 0, 0, 0);
      token(1, 100, 0, RSP_DATA, 64, "R3 IN before write");
      ctl(1, 0, 0, 0, 0, 0);
      check(ctl_rdata[0] == 1'b0, "R3 stall held back while busy", int'(ctl_rdata[0]), 0);
      token(1, 100, 0, RSP_DATA, 64, "R3 token while busy ignored");
      void'(sb.pop_back());
      check(sb.size() == 0, "R3 busy token produced nothing", sb.size(), 0);
      finish_x(1, 0); exp_tog = ~exp_tog;
      check(ctl_rdata[0] == 1'b1, "R3 stall applied at end", int'(ctl_rdata[0]), 1);
      token(1, 100, 0, RSP_STALL, 0, "R3 next token stalls");
      finish_x(1, 0);

      // R9 toggle writes
      ctl(0, 0, 1, 0, 0, 0); exp_tog = 0; chk_tog("R9 clear");
      ctl(0, 0, 0, 1, 0, 0); exp_tog = 1; chk_tog("R9 set");
      check(ctl_rdata[2] == 1'b1, "R9 status bit", int'(ctl_rdata[2]), 1);
      ctl(0, 0, 1, 1, 0, 0); exp_tog = 0; chk_tog("R9 clear wins");

      repeat (2) @(negedge clk);
      check(sb.size() == 0, "R4 all responses seen", sb.size(), 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule